// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block judges each incoming Ethernet frame by its 48-bit destination address and says whether the frame should be kept. A frame parser presents the address on a single cycle with a strobe. The block compares the address against the station address, spots the all-ones broadcast address and group (multicast) addresses, and looks up group addresses in a 64-entry hash table. One clock later it reports a keep/drop flag and a two-bit reason.

The filter setting is a ladder of six levels, and each level keeps everything the level below it keeps. From lowest to highest: nothing, own unicast only, plus broadcast, plus hashed multicast, plus every multicast, and finally every frame (promiscuous). The hash index is an XOR fold of the address into six bits. Bit 5 of the index picks one of two 32-bit table words, and bits 4:0 pick a bit inside that word. The station address, the table words and the level are sampled in the same cycle as the strobe. Changing them later never alters a decision that has already been taken.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: While `rst_n` is low and until the first strobe, `dec_valid_o`, `accept_o` and `reason_o` are all 0.
- R2: `dec_valid_o` is 1 in exactly the cycle after each cycle with `da_valid_i` high, and 0 otherwise. `accept_o` and `reason_o` update only in that cycle and otherwise hold their values.
- R3: `filt_level_i` encodes 0 = none, 1 = direct, 2 = broadcast, 3 = hashed multicast, 4 = all multicast, and 5, 6, 7 = promiscuous. At level 0 no frame is accepted.
- R4: A unicast address is accepted at levels 1 and above only if all 48 bits equal `station_addr_i`. An address differing in one bit is rejected below level 5.
- R5: The all-ones address is classified as broadcast, never as multicast. It is rejected at levels 0 and 1 and accepted at level 2 and above.
- R6: An address other than all-ones is multicast when bit 40 of `da_i` is 1. That bit is the least significant bit of the first-transmitted octet, which occupies `da_i[47:40]`.
- R7: The hash index is the XOR of the eight 6-bit slices `da_i[47:42]`, `da_i[41:36]`, ..., `da_i[5:0]`.
- R8: At level 3, a multicast address is accepted only when its table bit is set. Index bit 5 = 1 selects `mc_hash_hi_i` and 0 selects `mc_hash_lo_i`, and index bits 4:0 give the bit position.
- R9: At level 4, every multicast address is accepted whatever the table holds.
- R10: At levels 5 to 7, every address is accepted and the reason is 3.
- R11: Below level 5, the reason gives the address class whether or not the frame is accepted: 0 = unicast, 1 = broadcast, 2 = multicast.
- R12: A decision uses the configuration present in the cycle of its strobe. Configuration changes made afterwards do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| da_valid_i | input | 1 | Destination address strobe |
| da_i | input | 48 | Destination address, first-transmitted octet in bits 47:40 |
| station_addr_i | input | 48 | Own station address, same octet layout |
| mc_hash_lo_i | input | 32 | Hash table word for index bit 5 = 0 |
| mc_hash_hi_i | input | 32 | Hash table word for index bit 5 = 1 |
| filt_level_i | input | 3 | Filter level |
| dec_valid_o | output | 1 | Decision valid, one cycle after strobe |
| accept_o | output | 1 | Frame accepted |
| reason_o | output | 2 | Address class or promiscuous code |

## Verification
Every result, whether keep/drop, reason or valid flag, is due in the single clock edge after its strobe, because there is exactly one register between the inputs and the outputs. The bench drives each strobe on a falling edge. It samples the outputs on the next falling edge, after the capturing rising edge, and checks them again one cycle later to confirm that the valid flag has dropped and the decision has held. For the configuration-sampling checks, the configuration is changed in that same window between the capturing edge and the sample point.

// File: rtl/efilt_pkg.sv
`timescale 1ns/1ps
package efilt_pkg;
  localparam int LEVEL_W  = 3;
  localparam int REASON_W = 2;

  typedef enum logic [LEVEL_W-1:0] {
    LVL_NONE   = 3'd0,
    LVL_DIRECT = 3'd1,
    LVL_BCAST  = 3'd2,
    LVL_MCAST  = 3'd3,
    LVL_ALLMC  = 3'd4,
    LVL_ALL    = 3'd5
  } level_e;

  typedef enum logic [REASON_W-1:0] {
    RSN_UCAST   = 2'd0,
    RSN_BCAST   = 2'd1,
    RSN_MCAST   = 2'd2,
    RSN_PROMISC = 2'd3
  } reason_e;

  // true when a level is at or above a rung of the ladder
  function automatic logic level_at_least(input logic [LEVEL_W-1:0] lvl,
                                          input level_e rung);
    return lvl >= LEVEL_W'(rung);
  endfunction
endpackage

// File: rtl/efilt_classify.sv
`timescale 1ns/1ps
module efilt_classify
  import efilt_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int HASH_W = 6
) (
  input  logic [ADDR_W-1:0] da_i,
  input  logic [ADDR_W-1:0] station_i,
  output reason_e           cls_o,
  output logic              uc_hit_o,
  output logic [HASH_W-1:0] hash_idx_o
);
  localparam int NGRP      = ADDR_W / HASH_W;
  localparam int GROUP_BIT = ADDR_W - 8;

  // XOR of consecutive slices, starting at the top of the first octet
  function automatic logic [HASH_W-1:0] fold_addr(input logic [ADDR_W-1:0] a);
    logic [HASH_W-1:0] acc;
    acc = '0;
    for (int g = 0; g < NGRP; g++) begin
      acc ^= a[ADDR_W-1-g*HASH_W -: HASH_W];
    end
    return acc;
  endfunction

  logic is_bcast_w;
  logic is_mcast_w;

  assign is_bcast_w = &da_i;
  assign is_mcast_w = da_i[GROUP_BIT] & ~is_bcast_w;
  assign uc_hit_o   = (da_i == station_i);
  assign hash_idx_o = fold_addr(da_i);

  always_comb begin
    if (is_bcast_w)      cls_o = RSN_BCAST;
    else if (is_mcast_w) cls_o = RSN_MCAST;
    else                 cls_o = RSN_UCAST;
  end
endmodule

// File: rtl/efilt_hash_lookup.sv
`timescale 1ns/1ps
module efilt_hash_lookup #(
  parameter int WORD_W = 32,
  parameter int HASH_W = 6
) (
  input  logic [WORD_W-1:0] word_lo_i,
  input  logic [WORD_W-1:0] word_hi_i,
  input  logic [HASH_W-1:0] idx_i,
  input  logic              all_ones_i,
  output logic              hit_o
);
  localparam int TBL_W = 2 * WORD_W;

  logic [TBL_W-1:0] raw_tbl;
  logic [TBL_W-1:0] eff_tbl;

  // upper word sits above the lower one, so index bit 5 picks the word
  assign raw_tbl = {word_hi_i, word_lo_i};

  genvar b;
  generate
    for (b = 0; b < TBL_W; b++) begin : g_bit
      assign eff_tbl[b] = raw_tbl[b] | all_ones_i;
    end
  endgenerate

  assign hit_o = eff_tbl[idx_i];
endmodule

// File: rtl/efilt_decide.sv
`timescale 1ns/1ps
module efilt_decide
  import efilt_pkg::*;
(
  input  logic [LEVEL_W-1:0] level_i,
  input  reason_e            cls_i,
  input  logic               uc_hit_i,
  input  logic               hash_hit_i,
  output logic               accept_o,
  output reason_e            reason_o
);
  logic promisc_w;
  logic class_ok_w;

  assign promisc_w = level_at_least(level_i, LVL_ALL);

  always_comb begin
    unique case (cls_i)
      RSN_BCAST: class_ok_w = level_at_least(level_i, LVL_BCAST);
      RSN_MCAST: class_ok_w = level_at_least(level_i, LVL_MCAST) & hash_hit_i;
      default:   class_ok_w = level_at_least(level_i, LVL_DIRECT) & uc_hit_i;
    endcase
  end

  assign accept_o = promisc_w | class_ok_w;
  assign reason_o = promisc_w ? RSN_PROMISC : cls_i;
endmodule

// File: rtl/eth_rx_addr_filter.sv
`timescale 1ns/1ps
module eth_rx_addr_filter
  import efilt_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32,
  parameter int HASH_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                da_valid_i,
  input  logic [ADDR_W-1:0]   da_i,
  input  logic [ADDR_W-1:0]   station_addr_i,
  input  logic [WORD_W-1:0]   mc_hash_lo_i,
  input  logic [WORD_W-1:0]   mc_hash_hi_i,
  input  logic [LEVEL_W-1:0]  filt_level_i,
  output logic                dec_valid_o,
  output logic                accept_o,
  output logic [REASON_W-1:0] reason_o
);
  // named internal events, used by the assertions below
  reason_e           cls_w;
  logic              uc_hit_w;
  logic [HASH_W-1:0] hash_idx_w;
  logic              all_mc_w;
  logic              hash_hit_w;
  logic              acc_next_w;
  reason_e           rsn_next_w;

  efilt_classify #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_classify (
    .da_i       (da_i),
    .station_i  (station_addr_i),
    .cls_o      (cls_w),
    .uc_hit_o   (uc_hit_w),
    .hash_idx_o (hash_idx_w)
  );

  assign all_mc_w = level_at_least(filt_level_i, LVL_ALLMC);

  efilt_hash_lookup #(.WORD_W(WORD_W), .HASH_W(HASH_W)) u_lookup (
    .word_lo_i  (mc_hash_lo_i),
    .word_hi_i  (mc_hash_hi_i),
    .idx_i      (hash_idx_w),
    .all_ones_i (all_mc_w),
    .hit_o      (hash_hit_w)
  );

  efilt_decide u_decide (
    .level_i    (filt_level_i),
    .cls_i      (cls_w),
    .uc_hit_i   (uc_hit_w),
    .hash_hit_i (hash_hit_w),
    .accept_o   (acc_next_w),
    .reason_o   (rsn_next_w)
  );

  // single output stage: configuration is sampled with the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      reason_o    <= '0;
    end else begin
      dec_valid_o <= da_valid_i;
      if (da_valid_i) begin
        accept_o <= acc_next_w;
        reason_o <= rsn_next_w;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid_i |=> dec_valid_o);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid_i |=> !dec_valid_o);
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid_i |=> ($stable(accept_o) && $stable(reason_o)));
  assert_none_rejects_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid_i && filt_level_i == LEVEL_W'(LVL_NONE)) |=> !accept_o);
  assert_bcast_low_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid_i && cls_w == RSN_BCAST && filt_level_i < LEVEL_W'(LVL_BCAST))
      |=> (!accept_o && reason_o == REASON_W'(RSN_BCAST)));
  assert_allmc_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid_i && cls_w == RSN_MCAST && filt_level_i == LEVEL_W'(LVL_ALLMC))
      |=> accept_o);
  assert_promisc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid_i && filt_level_i >= LEVEL_W'(LVL_ALL))
      |=> (accept_o && reason_o == REASON_W'(RSN_PROMISC)));
endmodule

// File: tb/eth_rx_addr_filter_tb.sv
`timescale 1ns/1ps
module eth_rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic [47:0] station = 48'h02_11_22_33_44_55;
  logic [31:0] hlo = 32'h0000_4000;   // bit 14
  logic [31:0] hhi = 32'h0001_0000;   // bit 16 of upper word
  logic [2:0]  level = '0;
  logic        dec_valid;
  logic        accept;
  logic [1:0]  reason;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  eth_rx_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .da_valid_i(da_valid), .da_i(da),
    .station_addr_i(station), .mc_hash_lo_i(hlo), .mc_hash_hi_i(hhi),
    .filt_level_i(level), .dec_valid_o(dec_valid), .accept_o(accept),
    .reason_o(reason)
  );

  localparam logic [47:0] ADDR_TBL [7] = '{
    48'h02_11_22_33_44_55,   // own station
    48'h02_11_22_33_44_54,   // one bit off
    48'hFF_FF_FF_FF_FF_FF,   // broadcast
    48'h01_00_5E_00_00_01,   // group, hash 14 (lo word)
    48'h03_00_00_00_00_00,   // group, hash 48 (hi word bit 16)
    48'h33_33_00_00_00_FB,   // group, hash 11 (clear)
    48'h02_AA_BB_CC_DD_EE    // foreign unicast
  };

  // byte-wise restatement of the fold
  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [7:0] hv, x, y, z;
    hv = 8'h00;
    for (int t = 0; t < 2; t++) begin
      x = a[47-24*t -: 8];
      y = a[39-24*t -: 8];
      z = a[31-24*t -: 8];
      hv ^= (x >> 2) ^ (x << 4) ^ (y >> 4) ^ (y << 2) ^ (z >> 6) ^ z;
    end
    return hv[5:0];
  endfunction

  function automatic logic [2:0] ref_decide(input logic [2:0] lv, input logic [47:0] a);
    logic [1:0]  cls;
    logic        ok;
    logic [5:0]  h;
    logic [63:0] tbl;
    h   = ref_hash(a);
    tbl = {hhi, hlo};
    if (a == 48'hFFFF_FFFF_FFFF) cls = 2'd1;
    else if (a[40])              cls = 2'd2;
    else                         cls = 2'd0;
    case (cls)
      2'd1:    ok = (lv >= 3'd2);
      2'd2:    ok = (lv >= 3'd4) || (lv == 3'd3 && tbl[h]);
      default: ok = (lv >= 3'd1) && (a == station);
    endcase
    if (lv >= 3'd5) return {1'b1, 2'd3};
    return {ok, cls};
  endfunction

  function automatic string req_tag(input logic [2:0] lv, input logic [47:0] a);
    if (lv >= 3'd5)                  return "R10";
    if (lv == 3'd0)                  return "R3";
    if (a == 48'hFFFF_FFFF_FFFF)     return "R5";
    if (a[40] && lv == 3'd4)         return "R9";
    if (a[40] && lv == 3'd3)         return "R8";
    if (a[40])                       return "R6";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe on a falling edge, sample at the next falling edge
  task automatic strobe(input logic [2:0] lv, input logic [47:0] a);
    @(negedge clk);
    level    = lv;
    da       = a;
    da_valid = 1'b1;
    @(negedge clk);
    da_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] e;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, dec_valid}, 32'd0);
    check("R1 accept", {31'd0, accept}, 32'd0);
    check("R1 reason", {30'd0, reason}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {31'd0, dec_valid}, 32'd0);

    // table walk: every level against every address
    for (int lv = 0; lv < 8; lv++) begin
      for (int k = 0; k < 7; k++) begin
        strobe(3'(lv), ADDR_TBL[k]);
        e = ref_decide(3'(lv), ADDR_TBL[k]);
        check({req_tag(3'(lv), ADDR_TBL[k]), " accept"}, {31'd0, accept}, {31'd0, e[2]});
        check("R11 reason", {30'd0, reason}, {30'd0, e[1:0]});
        check("R2 valid", {31'd0, dec_valid}, 32'd1);
      end
    end

    // R7: known fold values (14 and 48)
    check("R7 hash a", {26'd0, ref_hash(48'h01_00_5E_00_00_01)}, 32'd14);
    check("R7 hash b", {26'd0, ref_hash(48'h03_00_00_00_00_00)}, 32'd48);

    // R8: table bit decides at level 3, word select by index bit 5
    hlo = 32'h0000_4000; hhi = 32'h0;
    strobe(3'd3, 48'h01_00_5E_00_00_01);
    check("R8 lo bit14 set", {31'd0, accept}, 32'd1);
    hlo = ~32'h0000_4000; hhi = 32'hFFFF_FFFF;
    strobe(3'd3, 48'h01_00_5E_00_00_01);
    check("R8 lo bit14 clear", {31'd0, accept}, 32'd0);
    hlo = 32'hFFFF_FFFF; hhi = ~32'h0001_0000;
    strobe(3'd3, 48'h03_00_00_00_00_00);
    check("R8 hi bit16 clear", {31'd0, accept}, 32'd0);
    hlo = 32'h0; hhi = 32'h0001_0000;
    strobe(3'd3, 48'h03_00_00_00_00_00);
    check("R8 hi bit16 set", {31'd0, accept}, 32'd1);
    check("R6 reason multicast", {30'd0, reason}, 32'd2);

    // R9: empty table, level 4
    hlo = 32'h0; hhi = 32'h0;
    strobe(3'd4, 48'h33_33_00_00_00_FB);
    check("R9 empty table", {31'd0, accept}, 32'd1);

    // R2: valid drops and outputs hold with no strobe
    @(negedge clk);
    check("R2 valid drop", {31'd0, dec_valid}, 32'd0);
    level = 3'd0; da = 48'h02_AA_BB_CC_DD_EE;
    @(negedge clk);
    check("R2 accept hold", {31'd0, accept}, 32'd1);
    check("R2 reason hold", {30'd0, reason}, 32'd2);

    // R2: back-to-back strobes
    @(negedge clk);
    level = 3'd1; da = station; da_valid = 1'b1;
    @(negedge clk);
    check("R2 b2b first", {31'd0, accept}, 32'd1);
    da = 48'h02_AA_BB_CC_DD_EE;
    @(negedge clk);
    da_valid = 1'b0;
    check("R2 b2b second", {31'd0, accept}, 32'd0);
    check("R2 b2b valid", {31'd0, dec_valid}, 32'd1);

    // R12: configuration changed right after the capturing edge
    @(negedge clk);
    level = 3'd1; da = station; da_valid = 1'b1;
    @(posedge clk);
    #1;
    da_valid = 1'b0; station = 48'h02_00_00_00_00_01; level = 3'd0;
    @(negedge clk);
    check("R12 old config used", {31'd0, accept}, 32'd1);
    strobe(3'd1, 48'h02_11_22_33_44_55);
    check("R12 new config used", {31'd0, accept}, 32'd0);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears accept", {31'd0, accept}, 32'd0);
    check("R1 reset clears reason", {30'd0, reason}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule